// File: doc/BRIEF.md
# Oversampled Gaussian Jitter Injector

This block sits between a clean serial test-pattern source and a serial output line, running on a fast clock with `OSR` ticks per unit interval. The source pushes bits through a valid/ready port into a small elastic buffer. The output scheduler keeps an ideal edge grid, one grid edge every `OSR` ticks. Each grid edge is moved by a signed whole-tick offset drawn for that edge alone. The line holds each bit for `OSR` ticks plus the next offset minus the current one. In effect, oversampled copies of the level are added or removed.

Offsets come from a central-limit approximation of a Gaussian. Twelve bytes taken from a fast-stepping 32-bit maximal-length LFSR are summed and their mean is removed. The result is scaled by the run-time `sigma` input and clamped so that two edges can never meet or cross. Each offset is measured from the ideal grid and is never added to the one before it, so the average bit rate stays exactly one bit per `OSR` ticks. `sigma` may be changed at any time to sweep the jitter level.

Back-pressure rules: a bit is taken on every rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops only while the buffer is full. A source that is locked to the bit rate and cannot wait sees `overflow` during such a stall. Output starts only once the buffer is half full.

Top module: `jit_injector`

## Requirements
- R1: A bit is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly while the buffer holds `DEPTH` bits. `overflow` is high in any cycle where `in_valid` is high and `in_ready` is low.
- R2: Emission begins only after the buffer holds `DEPTH/2` bits. Bits then leave in acceptance order, with no loss and no repetition.
- R3: Two `out_start` pulses are never on adjacent ticks, so every emitted bit lasts at least two ticks.
- R4: With `sigma` at zero, consecutive `out_start` pulses are exactly `OSR` ticks apart on a fixed grid.
- R5: Each bit start lies within ±(`OSR`/2−1) ticks of its own ideal grid point, and errors do not accumulate.
- R6: `out_line` changes only in a tick where `out_start` is high, and it then carries the bit being emitted.
- R7: The offset spread grows with `sigma`. The standard deviation is about `sigma`/16 ticks before clamping, so the sample variance rises as `sigma` steps through 0, 16, 48 and 160.
- R8: When an edge is due and the buffer is empty, `underflow` pulses for that tick. In that tick `out_start` stays low and `out_line` holds its level.
- R9: During reset, `out_line`, `out_start` and `underflow` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversample clock, `OSR` ticks per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source offers a bit |
| in_ready | output | 1 | Buffer can take a bit |
| in_bit | input | 1 | Offered data bit |
| sigma | input | SIGMA_W | Jitter level, 1/16 tick of standard deviation per step |
| out_line | output | 1 | Jittered serial line |
| out_start | output | 1 | High in the first tick of each emitted bit |
| overflow | output | 1 | Offered bit refused because the buffer is full |
| underflow | output | 1 | Edge due with an empty buffer |

## Verification
The assertions assume that `OSR` is a power of two of at least eight, so that the three-tick offset draw finishes before any early edge can fall due. They also assume that `in_valid` and `sigma` change only between clock edges. The bench drives every input at the falling edge and keeps the default `OSR`. It changes `sigma` only while the block is running and lets a few bits pass before it measures. The feed is held continuous until the final drain, so underflow is provoked only on purpose.

// File: rtl/jit_pkg.sv
package jit_pkg;
  localparam int          LFSR_W      = 32;
  localparam logic [31:0] LFSR_TAPS   = 32'h8020_0003;
  localparam logic [31:0] LFSR_SEED   = 32'h1D0C_5A37;
  localparam int          SUM_TERMS   = 12;
  localparam int          BYTES_TICK  = 4;
  localparam int          DRAW_TICKS  = SUM_TERMS / BYTES_TICK;
  localparam int          SUM_MEAN    = 1530;
endpackage

// File: rtl/jit_lfsr.sv
module jit_lfsr #(
  parameter int          W     = 32,
  parameter logic [W-1:0] TAPS = '1,
  parameter logic [W-1:0] SEED = 1,
  parameter int          STEP  = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  function automatic logic [W-1:0] leap(input logic [W-1:0] s);
    logic [W-1:0] v;
    v = s;
    for (int i = 0; i < STEP; i++) v = v[0] ? ((v >> 1) ^ TAPS) : (v >> 1);
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEED;
    else        state <= leap(state);
  end

  // R7: the generator must never lock up in the all-zero state
  a_r7_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n) state != '0);
endmodule

// File: rtl/jit_gauss.sv
module jit_gauss import jit_pkg::*; #(
  parameter int OSR     = 16,
  parameter int SIGMA_W = 8,
  parameter int SHIFT   = 12,
  parameter int PH_W    = $clog2(OSR),
  parameter int OFF_W   = PH_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PH_W-1:0]         ph,
  input  logic [SIGMA_W-1:0]      sigma,
  output logic signed [OFF_W-1:0] off
);
  localparam int CLAMP = OSR / 2 - 1;
  localparam int BS_W  = 10;
  localparam int ACC_W = 12;

  logic [LFSR_W-1:0] rnd;
  logic [BS_W-1:0]   bsum;
  logic [ACC_W-1:0]  acc;
  logic signed [OFF_W-1:0] off_next;

  jit_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .STEP(LFSR_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(rnd)
  );

  always_comb begin
    bsum = '0;
    for (int b = 0; b < BYTES_TICK; b++) bsum = bsum + BS_W'(rnd[8*b +: 8]);
  end

  always_comb begin
    int centred, prod, scaled;
    centred = int'(acc) - SUM_MEAN;
    prod    = centred * int'(sigma);
    scaled  = (prod + (1 <<< (SHIFT - 1))) >>> SHIFT;
    if (scaled > CLAMP)  scaled = CLAMP;
    if (scaled < -CLAMP) scaled = -CLAMP;
    off_next = OFF_W'(scaled);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      off <= '0;
    end else begin
      if (ph == '0)                        acc <= ACC_W'(bsum);
      else if (int'(ph) < DRAW_TICKS)      acc <= acc + ACC_W'(bsum);
      if (int'(ph) == DRAW_TICKS)          off <= off_next;
    end
  end

  // R5: a drawn offset never leaves the no-crossing window
  a_r5_offset_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(off) <= CLAMP) && (int'(off) >= -CLAMP));
  // R4: a draw taken with zero sigma yields a zero offset
  a_r4_zero_sigma: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ph) == DRAW_TICKS && sigma == '0) |=> off == '0);
endmodule

// File: rtl/jit_fifo.sv
module jit_fifo #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic        din,
  input  logic        pop,
  output logic        dout,
  output logic        full,
  output logic        empty,
  output logic [AW:0] count
);
  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wp, rp;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; mem <= '0;
    end else begin
      if (push) begin
        mem[wp] <= din;
        wp      <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1: the store never holds more than its depth
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
  // R2: a read is never taken from an empty store
  a_r2_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/jit_injector.sv
module jit_injector import jit_pkg::*; #(
  parameter int OSR     = 16,
  parameter int DEPTH   = 8,
  parameter int SIGMA_W = 8,
  parameter int SHIFT   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_bit,
  input  logic [SIGMA_W-1:0] sigma,
  output logic               out_line,
  output logic               out_start,
  output logic               overflow,
  output logic               underflow
);
  localparam int PH_W  = $clog2(OSR);
  localparam int OFF_W = PH_W + 1;
  localparam int AW    = $clog2(DEPTH);
  localparam int PRIME = DEPTH / 2;
  localparam int MID   = OSR / 2;

  initial begin
    assert (OSR >= 8 && (OSR & (OSR - 1)) == 0);
  end

  logic [PH_W-1:0]         ph;
  logic signed [OFF_W-1:0] gen_off, cur_off;
  logic                    started;
  logic                    push, pop, edge_due;
  logic                    f_dout, f_full, f_empty;
  logic [AW:0]             f_count;

  jit_gauss #(.OSR(OSR), .SIGMA_W(SIGMA_W), .SHIFT(SHIFT), .PH_W(PH_W), .OFF_W(OFF_W)) u_gauss (
    .clk(clk), .rst_n(rst_n), .ph(ph), .sigma(sigma), .off(gen_off)
  );

  jit_fifo #(.DEPTH(DEPTH), .AW(AW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(in_bit), .pop(pop),
    .dout(f_dout), .full(f_full), .empty(f_empty), .count(f_count)
  );

  assign in_ready = !f_full;
  assign overflow = in_valid && f_full;
  assign push     = in_valid && !f_full;

  // Late edge of this grid point fires after it; early edge of the next fires before it.
  always_comb begin
    logic late_hit, early_hit;
    late_hit  = (int'(cur_off) >= 0) && (int'(ph) == int'(cur_off));
    early_hit = (int'(gen_off) < 0)  && (int'(ph) == OSR + int'(gen_off));
    edge_due  = started && (late_hit || early_hit);
  end

  assign pop = edge_due && !f_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= '0;
      cur_off   <= '0;
      started   <= 1'b0;
      out_line  <= 1'b0;
      out_start <= 1'b0;
      underflow <= 1'b0;
    end else begin
      ph <= ph + 1'b1;
      if (int'(ph) == OSR - 1) cur_off <= gen_off;
      if (!started && int'(ph) == MID && int'(f_count) >= PRIME) started <= 1'b1;
      out_start <= pop;
      underflow <= edge_due && f_empty;
      if (pop) out_line <= f_dout;
    end
  end

  // R3: two bit starts never sit on adjacent ticks
  a_r3_edge_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |=> !out_start);
  // R6: the line moves only with a bit start
  a_r6_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_start |-> $stable(out_line));
  // R8: a starved edge is never also a bit start
  a_r8_starve_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_start, underflow}));
  // R2: nothing is emitted before priming
  a_r2_primed: assert property (@(posedge clk) disable iff (!rst_n)
    !started |=> !out_start);
endmodule

// File: tb/jit_injector_test.sv
`timescale 1ns/1ps
module jit_injector_test;
  localparam int OSR = 16;
  localparam int N   = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0;
  logic [7:0] sigma = 8'd0;
  logic in_ready, out_line, out_start, overflow, underflow;

  jit_injector uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .sigma(sigma), .out_line(out_line), .out_start(out_start),
    .overflow(overflow), .underflow(underflow)
  );

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit sent [N];
  bit rxb  [N];
  int rxt  [N];
  int ns = 0, nrx = 0, tick = 0;
  int line_bad = 0, ovf_bad = 0, ovf_seen = 0, unf_seen = 0, late_start = 0;
  bit feed_en = 0, prev_line = 0, done = 0;
  logic [15:0] pat = 16'hACE1;
  int grid_r = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wrap_off(input int t);
    int m;
    m = (((t - grid_r) % OSR) + OSR) % OSR;
    return (m > OSR / 2) ? m - OSR : m;
  endfunction

  // Source: offers bits at the falling edge, records what the next rising edge takes.
  initial begin
    forever begin
      @(negedge clk);
      if (feed_en && rst_n) begin
        in_valid = 1'b1;
        in_bit   = pat[0];
        #0.1;
        if (overflow !== !in_ready) ovf_bad++;
        if (overflow) ovf_seen++;
        if (in_ready && ns < N) begin
          sent[ns] = in_bit;
          ns++;
          pat = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
        end
      end else begin
        in_valid = 1'b0;
      end
    end
  end

  // Monitor: records each bit start and its tick.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        tick++;
        if (out_start) begin
          if (nrx < N) begin rxb[nrx] = out_line; rxt[nrx] = tick; end
          nrx++;
          if (unf_seen > 0) late_start++;
        end else if (out_line !== prev_line) line_bad++;
        if (underflow) unf_seen++;
        prev_line = out_line;
      end
    end
  end

  task automatic wait_rx(input int n);
    while (nrx < n) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(out_line == 1'b0, "R9 line", out_line, 0);
    chk(out_start == 1'b0, "R9 start", out_start, 0);
    chk(underflow == 1'b0, "R9 underflow", underflow, 0);
    chk(in_ready == 1'b1, "R9 ready", in_ready, 1);
    rst_n = 1'b1;
    feed_en = 1'b1;
  endtask

  task automatic t_clean;
    int bad_gap = 0, bad_bit = 0;
    wait_rx(40);
    grid_r = rxt[0] % OSR;
    for (int i = 1; i < 40; i++) if (rxt[i] - rxt[i-1] != OSR) bad_gap++;
    for (int i = 0; i < 40; i++) if (rxb[i] != sent[i]) bad_bit++;
    chk(bad_gap == 0, "R4 grid spacing", bad_gap, 0);
    chk(bad_bit == 0, "R2 order clean", bad_bit, 0);
    chk(line_bad == 0, "R6 line clean", line_bad, 0);
  endtask

  task automatic t_sweep;
    int   sig [3] = '{16, 48, 160};
    real  prev_var = 0.0;
    for (int s = 0; s < 3; s++) begin
      int  mark, max_abs = 0, min_gap = 1000;
      real sum = 0.0, sq = 0.0, mean, v;
      sigma = 8'(sig[s]);
      wait_rx(nrx + 4);
      mark = nrx;
      wait_rx(mark + 256);
      for (int i = mark; i < mark + 256; i++) begin
        int o;
        o = wrap_off(rxt[i]);
        if ((o < 0 ? -o : o) > max_abs) max_abs = (o < 0 ? -o : o);
        if (rxt[i] - rxt[i-1] < min_gap) min_gap = rxt[i] - rxt[i-1];
        sum += o; sq += o * o;
      end
      mean = sum / 256.0;
      v = sq / 256.0 - mean * mean;
      chk(max_abs <= OSR / 2 - 1, "R5 clamp", max_abs, OSR / 2 - 1);
      chk(min_gap >= 2, "R3 min duration", min_gap, 2);
      chk(v > prev_var, "R7 variance rises", int'(v * 100.0), int'(prev_var * 100.0));
      prev_var = v;
    end
  endtask

  task automatic t_handshake;
    chk(ovf_bad == 0, "R1 overflow vs ready", ovf_bad, 0);
    chk(ovf_seen > 0, "R1 stall seen", ovf_seen, 1);
  endtask

  task automatic t_drain;
    int bad_bit = 0;
    feed_en = 1'b0;
    repeat (300) @(negedge clk);
    chk(nrx == ns, "R2 all delivered", nrx, ns);
    for (int i = 0; i < ns && i < N; i++) if (rxb[i] != sent[i]) bad_bit++;
    chk(bad_bit == 0, "R2 order full run", bad_bit, 0);
    chk(unf_seen > 0, "R8 underflow seen", unf_seen, 1);
    chk(late_start == 0, "R8 no start when starved", late_start, 0);
    chk(line_bad == 0, "R6 line only at start", line_bad, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_clean;
    t_sweep;
    t_handshake;
    t_drain;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule